// File: doc/BRIEF.md
# Upper-Memory Shadow Attribute Decoder

This block decides, for any address presented to it, where a memory access in the upper-memory window (0xA0000 up to 0xFFFFF) is routed. The window is cut into 24 segments of 16 KB. Each segment has a 2-bit routing code that picks internal DRAM or the external bus, separately for reads and for writes. Each segment also has a 2-bit protect code that can block writes no matter what the routing code says. Addresses outside the window are always treated as plain internal memory.

The routing codes live in six control registers and the protect codes in six protect registers. Each register covers one 64 KB block and holds four 2-bit fields. Software-facing logic elsewhere writes them through a parallel load port. The lookup from address to attributes is purely combinational. Two summary flags report whether the BIOS area (0xE0000 and up) is shadowed for reads or for writes. A one-cycle pulse follows every accepted register load, so that downstream translation caches can be flushed.

Top module: `shadow_attr_decoder`

## Requirements
- R1: An in-window address selects register number (addr − 0xA0000) >> 16 and field n = bits [15:14] of that offset. Field n sits at register bits [2n+1:2n].
- R2: A routing code with bit 1 set (10, 11) routes reads internal (`readInternal`=1). Codes 00 and 01 route reads external.
- R3: When the segment is not write-blocked, a routing code with bit 0 set (01, 11) gives `writeInternal`=1. Codes 00 and 10 give `writeInternal`=0, which means the write goes external.
- R4: A protect code of exactly 01 sets `writeBlocked`=1 and forces `writeInternal`=0 for any routing code. Protect codes 00, 10 and 11 never block.
- R5: `biosReadShadow` is 1 exactly when some segment in registers 4 or 5 (0xE0000 and up) has routing bit 1 set.
- R6: `biosWriteShadow` is 1 exactly when some segment in registers 4 or 5 has routing bit 0 set and protect bit 0 clear. A protect code of 11 clears the flag without blocking writes.
- R7: An address below 0xA0000 or above 0xFFFFF gives `readInternal`=1, `writeInternal`=1 and `writeBlocked`=0.
- R8: A load with `loadValid`=1 writes `loadData` into the control register (`loadSel`=0) or the protect register (`loadSel`=1) numbered `loadIdx` (0 to 5). The new value governs lookups from the next clock edge.
- R9: `attrChanged` is high for exactly the one cycle after each accepted load. It stays high on consecutive cycles for back-to-back loads.
- R10: A load with `loadIdx` of 6 or 7 changes no register and raises no `attrChanged` pulse.
- R11: Reset (`rstN` low) clears every register and `attrChanged`. The whole window then reads and writes external, unprotected, with both BIOS flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Register load request |
| loadSel | input | 1 | 0 = control register, 1 = protect register |
| loadIdx | input | 3 | Register number, 0 to 5 valid |
| loadData | input | 8 | Four 2-bit segment fields |
| lookupAddr | input | 24 | Address to classify |
| readInternal | output | 1 | Read goes to internal DRAM |
| writeInternal | output | 1 | Write goes to internal DRAM |
| writeBlocked | output | 1 | Write is discarded |
| biosReadShadow | output | 1 | BIOS area shadowed for reads |
| biosWriteShadow | output | 1 | BIOS area shadowed for writes |
| attrChanged | output | 1 | One-cycle pulse after an accepted load |

## Verification
The bench visits all four routing codes in one register, including the first and last byte of a segment. A field decoder that is off by one would report the code of the neighbouring segment there. It tries every protect code on a routed-internal segment, because a design that blocks on "bit 0 set" rather than on exactly 01 would wrongly block under code 11. For the same reason it checks that code 11 still clears the write-shadow flag. It probes the bytes just below and above the window, where a bounds error would hand out external or blocked attributes. It also loads indices 6 and 7 and then shows, through the lookup outputs and the missing pulse, that no register was aliased.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int NUM_BLOCKS = 6;
  localparam int FIELDS = 4;
  localparam int CODE_W = 2;
  localparam int REG_W = FIELDS * CODE_W;
  localparam int IDX_W = $clog2(NUM_BLOCKS + 2);
  localparam int BIOS_FIRST_BLOCK = 4;
  localparam logic [CODE_W-1:0] PROT_BLOCK = 2'b01;

  typedef logic [NUM_BLOCKS-1:0][REG_W-1:0] regBank_t;

  typedef struct packed {
    logic [NUM_BLOCKS-1:0] ctrlWe;
    logic [NUM_BLOCKS-1:0] protWe;
    logic [REG_W-1:0]      data;
  } loadStrobe_t;
endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadValid,
  input  logic             loadSel,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic [REG_W-1:0] loadData,
  output loadStrobe_t      strobe,
  output logic             attrChanged
);
  logic idxOk;
  logic accepted;

  assign idxOk = (loadIdx < IDX_W'(NUM_BLOCKS));
  assign accepted = loadValid && idxOk;

  always_comb begin
    strobe = '0;
    strobe.data = loadData;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      strobe.ctrlWe[b] = loadValid && !loadSel && (loadIdx == IDX_W'(b));
      strobe.protWe[b] = loadValid && loadSel && (loadIdx == IDX_W'(b));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) attrChanged <= 1'b0;
    else       attrChanged <= accepted;
  end

  // R9: an accepted load is followed by a change pulse
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && loadIdx < IDX_W'(NUM_BLOCKS)) |=> attrChanged);

  // R10: out-of-range index raises no strobe
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (loadIdx >= IDX_W'(NUM_BLOCKS)) |-> (strobe.ctrlWe == '0 && strobe.protWe == '0));
endmodule

// File: rtl/shadow_regs.sv
module shadow_regs
  import shadow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  loadStrobe_t strobe,
  output regBank_t    ctrlRegs,
  output regBank_t    protRegs,
  output logic        biosReadShadow,
  output logic        biosWriteShadow
);
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_block
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlRegs[b] <= '0;
        protRegs[b] <= '0;
      end else begin
        if (strobe.ctrlWe[b]) ctrlRegs[b] <= strobe.data;
        if (strobe.protWe[b]) protRegs[b] <= strobe.data;
      end
    end
  end

  always_comb begin
    biosReadShadow = 1'b0;
    biosWriteShadow = 1'b0;
    for (int b = BIOS_FIRST_BLOCK; b < NUM_BLOCKS; b++) begin
      for (int f = 0; f < FIELDS; f++) begin
        biosReadShadow  = biosReadShadow  | ctrlRegs[b][f*CODE_W+1];
        biosWriteShadow = biosWriteShadow |
                          (ctrlRegs[b][f*CODE_W] & ~protRegs[b][f*CODE_W]);
      end
    end
  end

  // R8: registers only change on a load strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ctrlWe == '0 && strobe.protWe == '0) |=> ($stable(ctrlRegs) && $stable(protRegs)));
endmodule

// File: rtl/shadow_lookup.sv
module shadow_lookup
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [31:0] WINDOW_BASE = 32'h000A_0000,
  parameter int SEG_SHIFT = 14,
  parameter int BLOCK_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  regBank_t          ctrlRegs,
  input  regBank_t          protRegs,
  output logic              readInternal,
  output logic              writeInternal,
  output logic              writeBlocked
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WINDOW_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI =
    ADDR_W'(WINDOW_BASE + 32'(NUM_BLOCKS) * (32'd1 << BLOCK_SHIFT));
  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam int FLD_W = $clog2(FIELDS);

  logic [ADDR_W-1:0] offset;
  logic              inWindow;
  logic [BLK_W-1:0]  blk;
  logic [FLD_W-1:0]  fld;
  logic [CODE_W-1:0] route;
  logic [CODE_W-1:0] prot;

  assign inWindow = (addr >= WIN_LO) && (addr < WIN_HI);
  assign offset = addr - WIN_LO;
  assign blk = inWindow ? offset[BLOCK_SHIFT +: BLK_W] : '0;
  assign fld = offset[SEG_SHIFT +: FLD_W];

  always_comb begin
    route = ctrlRegs[blk][{fld, 1'b0} +: CODE_W];
    prot  = protRegs[blk][{fld, 1'b0} +: CODE_W];
    if (!inWindow) begin
      readInternal  = 1'b1;
      writeInternal = 1'b1;
      writeBlocked  = 1'b0;
    end else begin
      readInternal  = route[1];
      writeBlocked  = (prot == PROT_BLOCK);
      writeInternal = route[0] && (prot != PROT_BLOCK);
    end
  end

  // R4: a blocked write never also routes internal
  p_block_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    writeBlocked |-> !writeInternal);

  // R7: outside the window everything is plain internal memory
  p_outside_r7: assert property (@(posedge clk) disable iff (!rstN)
    (addr < WIN_LO || addr >= WIN_HI) |-> (readInternal && writeInternal && !writeBlocked));
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic              loadSel,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [REG_W-1:0]  loadData,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              readInternal,
  output logic              writeInternal,
  output logic              writeBlocked,
  output logic              biosReadShadow,
  output logic              biosWriteShadow,
  output logic              attrChanged
);
  loadStrobe_t strobe;
  regBank_t    ctrlRegs;
  regBank_t    protRegs;

  shadow_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadSel(loadSel),
    .loadIdx(loadIdx), .loadData(loadData), .strobe(strobe),
    .attrChanged(attrChanged)
  );

  shadow_regs u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctrlRegs(ctrlRegs),
    .protRegs(protRegs), .biosReadShadow(biosReadShadow),
    .biosWriteShadow(biosWriteShadow)
  );

  shadow_lookup #(.ADDR_W(ADDR_W)) u_lookup (
    .clk(clk), .rstN(rstN), .addr(lookupAddr), .ctrlRegs(ctrlRegs),
    .protRegs(protRegs), .readInternal(readInternal),
    .writeInternal(writeInternal), .writeBlocked(writeBlocked)
  );
endmodule

// File: tb/shadow_attr_decoder_bench.sv
module shadow_attr_decoder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadValid = 1'b0;
  logic loadSel = 1'b0;
  logic [2:0] loadIdx = '0;
  logic [7:0] loadData = '0;
  logic [23:0] lookupAddr = '0;
  logic readInternal, writeInternal, writeBlocked;
  logic biosReadShadow, biosWriteShadow, attrChanged;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  shadow_attr_decoder u_shadow_attr_decoder (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadSel(loadSel),
    .loadIdx(loadIdx), .loadData(loadData), .lookupAddr(lookupAddr),
    .readInternal(readInternal), .writeInternal(writeInternal),
    .writeBlocked(writeBlocked), .biosReadShadow(biosReadShadow),
    .biosWriteShadow(biosWriteShadow), .attrChanged(attrChanged)
  );

  typedef struct packed {
    logic        doLoad;
    logic        sel;
    logic [2:0]  idx;
    logic [7:0]  data;
    logic [23:0] addr;
    logic        rd;
    logic        wr;
    logic        blk;
    logic        br;
    logic        bw;
  } vec_t;

  // Register state accumulates from one row to the next.
  localparam vec_t VECS [15] = '{
    '{1'b1, 1'b0, 3'd0, 8'b11_10_01_00, 24'h0A0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 3'd0, 8'h00,          24'h0A4000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 3'd0, 8'h00,          24'h0ABFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 3'd0, 8'h00,          24'h0AC000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 3'd0, 8'b01_00_00_00, 24'h0AFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 3'd0, 8'b11_00_00_00, 24'h0AC000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 3'd4, 8'b00_00_00_10, 24'h0E0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 3'd5, 8'b01_00_00_00, 24'h0FFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 3'd5, 8'b11_00_00_00, 24'h0FFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 3'd5, 8'b10_00_00_00, 24'h0FFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b0, 3'd0, 8'h00,          24'h09FFFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b0, 3'd0, 8'h00,          24'h100000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 3'd3, 8'hFF,          24'h0D8000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 3'd2, 8'h55,          24'h0C4000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 3'd1, 8'hAA,          24'h0B8000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive a load at a falling edge; returns at the next falling edge.
  task automatic doLoad(input logic sel, input logic [2:0] idx, input logic [7:0] data);
    @(negedge clk);
    loadValid = 1'b1; loadSel = sel; loadIdx = idx; loadData = data;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic lookAt(input logic [23:0] a);
    lookupAddr = a;
    #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    lookAt(24'h0C0000);
    chk("R11 rd", readInternal, 0);
    chk("R11 wr", writeInternal, 0);
    chk("R11 blk", writeBlocked, 0);
    chk("R11 bios", {biosReadShadow, biosWriteShadow}, 0);
    chk("R11 pulse", attrChanged, 0);

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: vector table
    foreach (VECS[i]) begin
      if (VECS[i].doLoad) begin
        doLoad(VECS[i].sel, VECS[i].idx, VECS[i].data);
        chk($sformatf("R9 pulse v%0d", i), attrChanged, 1);
      end else begin
        @(negedge clk);
        chk($sformatf("R9 quiet v%0d", i), attrChanged, 0);
      end
      lookAt(VECS[i].addr);
      chk($sformatf("R1 R2 rd v%0d", i), readInternal, VECS[i].rd);
      chk($sformatf("R3 R8 wr v%0d", i), writeInternal, VECS[i].wr);
      chk($sformatf("R4 R7 blk v%0d", i), writeBlocked, VECS[i].blk);
      chk($sformatf("R5 v%0d", i), biosReadShadow, VECS[i].br);
      chk($sformatf("R6 v%0d", i), biosWriteShadow, VECS[i].bw);
    end

    // R4: protect code 10 does not block (register 1 field 2 routes 10)
    doLoad(1'b1, 3'd1, 8'b00_10_00_00);
    lookAt(24'h0B8000);
    chk("R4 prot10 blk", writeBlocked, 0);
    // R4: protect 01 blocks even with routing 11 (register 3)
    doLoad(1'b1, 3'd3, 8'b00_00_00_01);
    lookAt(24'h0D0000);
    chk("R4 prot01 blk", writeBlocked, 1);
    chk("R4 prot01 wr", writeInternal, 0);
    lookAt(24'h0D4000);
    chk("R1 neighbour unblocked", writeBlocked, 0);

    // R9: pulse lasts one cycle; back-to-back loads hold it high
    @(negedge clk);
    chk("R9 pulse drop", attrChanged, 0);
    @(negedge clk);
    loadValid = 1'b1; loadSel = 1'b0; loadIdx = 3'd0; loadData = 8'h00;
    @(negedge clk);
    loadIdx = 3'd2;
    chk("R9 back1", attrChanged, 1);
    @(negedge clk);
    loadValid = 1'b0;
    chk("R9 back2", attrChanged, 1);
    @(negedge clk);
    chk("R9 back end", attrChanged, 0);

    // R10: indices 6 and 7 are ignored
    doLoad(1'b0, 3'd6, 8'hFF);
    chk("R10 no pulse6", attrChanged, 0);
    doLoad(1'b1, 3'd7, 8'h55);
    chk("R10 no pulse7", attrChanged, 0);
    lookAt(24'h0A0000);
    chk("R10 reg0 rd", readInternal, 0);
    chk("R10 reg0 wr", writeInternal, 0);
    lookAt(24'h0A4000);
    chk("R10 reg0 blk", writeBlocked, 0);
    lookAt(24'h0C8000);
    chk("R10 reg2 wr", writeInternal, 0);
    chk("R10 bios", {biosReadShadow, biosWriteShadow}, 2'b11);

    // R11: reset mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    lookAt(24'h0FFFFF);
    chk("R11 again rd", readInternal, 0);
    chk("R11 again wr", writeInternal, 0);
    lookAt(24'h0D0000);
    chk("R11 again blk", writeBlocked, 0);
    chk("R11 again bios", {biosReadShadow, biosWriteShadow}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule